// File: doc/BRIEF.md
# Address Translation Unit with Hardware Table Walk

This unit maps a 32-bit virtual address to a physical address. A small, fully associative lookaside store holds recent page translations. Each slot keeps a virtual page number as its key and a physical frame number as its value. Every lookup compares the requested page number against all slots at once. A hit returns the frame number joined with the untouched 12-bit page offset.

When no slot matches, a hardware walker reads one 32-bit table entry from memory. The address of that entry is the table base register plus the page number times four. If bit 0 of the entry is set, the walker installs the entry in the store and answers the request. If bit 0 is clear, the walker reports a page fault and installs nothing. Loading the base register switches to a different page table, and the load invalidates every stored translation.

The controller has five named states:
- `ST_IDLE` accepts a request and goes to `ST_LOOKUP`.
- `ST_LOOKUP` goes to `ST_IDLE` on a hit, with the response given in that cycle. On a miss it goes to `ST_WALK_REQ`.
- `ST_WALK_REQ` issues the memory read and goes to `ST_WALK_WAIT`.
- `ST_WALK_WAIT` waits for the memory response, refills the store if the entry is valid, and goes to `ST_DONE`.
- `ST_DONE` gives the response or the fault and goes to `ST_IDLE`.

Top module: `mmu_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, `mem_req_valid` is 0, and no slot holds a translation, so the first lookup misses.
- R2: On a hit, `rsp_valid` is 1 in the cycle after the request is accepted, with `rsp_fault` 0 and no memory read issued.
- R3: On a miss, exactly one memory read is issued, two cycles after acceptance. Its address is `base + (vaddr[31:12] << 2)`.
- R4: A walk answers in the cycle after `mem_rsp_valid`.
- R5: After a successful walk, a new request to the same page hits, whatever its offset.
- R6: If the fetched entry has bit 0 clear, the response has `rsp_fault` 1 and `rsp_paddr` 0. No slot is filled, so a repeat request walks again.
- R7: `req_ready` is 0 from the cycle after acceptance through the response cycle, and is 1 again in the cycle after the response.
- R8: A base register write takes effect at the next edge. Later walks use the new base, and every earlier translation misses.
- R9: A refill takes the lowest-numbered empty slot. When every slot is full, it takes the slot named by a rotating pointer. The pointer starts at slot 0, steps by one for each such replacement, and returns to 0 on a base write.
- R10: At most one memory read is outstanding. `mem_req_valid` is a single-cycle pulse and does not repeat before the response arrives.
- R11: Lookups compare all 20 page-number bits. Pages that differ only in `vaddr[31]` are separate translations.
- R12: The physical address is `{entry[31:12], vaddr[11:0]}`: the entry's upper 20 bits are the frame number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_fault | output | 1 | Page fault: the table entry was not valid |
| base_we | input | 1 | Load the table base register |
| base_wdata | input | 32 | New table base, 4-byte aligned |
| mem_req_valid | output | 1 | Table entry read request (pulse) |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Table entry: bit 0 valid, bits 31:12 frame |

## Verification
The bench builds the unit with four slots instead of the default sixteen. A handful of distinct pages is then enough to fill the store and force round-robin replacement several times over, with the victim pointer wrapping. Memory latency varies from one to three cycles, which exercises the wait state at different lengths. The default address widths are kept, so the page pair that differs only in the top bit checks the full-width compare.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WALK_REQ,
        ST_WALK_WAIT,
        ST_DONE
    } xl_state_e;

    localparam int PTE_VALID_BIT = 0;

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [VPN_W-1:0]   wr_vpn,
    input  logic [PFN_W-1:0]   wr_pfn,
    input  logic [VPN_W-1:0]   lk_vpn,
    output logic               lk_hit,
    output logic [PFN_W-1:0]   lk_pfn,
    output logic [ENTRIES-1:0] valid_vec
);

    logic [ENTRIES-1:0] match;
    logic [PFN_W-1:0]   pfn_gated [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        logic             slot_v;
        logic [VPN_W-1:0] slot_vpn;
        logic [PFN_W-1:0] slot_pfn;
        logic             slot_wr;

        assign slot_wr = wr_en && (wr_idx == IDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_v <= 1'b0;
            end else if (flush) begin
                slot_v <= 1'b0;
            end else if (slot_wr) begin
                slot_v <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (slot_wr) begin
                slot_vpn <= wr_vpn;
                slot_pfn <= wr_pfn;
            end
        end

        assign match[i]     = slot_v && (slot_vpn == lk_vpn);
        assign pfn_gated[i] = match[i] ? slot_pfn : '0;
        assign valid_vec[i] = slot_v;
    end

    // Keys are unique, so at most one slot matches and an OR merges the values.
    always_comb begin
        lk_pfn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            lk_pfn = lk_pfn | pfn_gated[i];
        end
    end

    assign lk_hit = |match;

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic               fill,
    output logic [IDX_W-1:0]   victim_idx
);

    logic             free_found;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] rr_q;

    // Scan from the top so that the lowest empty slot is the one kept.
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    assign victim_idx = free_found ? free_idx : rr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (flush) begin
            rr_q <= '0;
        end else if (fill && !free_found) begin
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end

endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
    import mmu_pkg::*;
#(
    parameter int VA_W        = 32,
    parameter int PA_W        = 32,
    parameter int PAGE_BITS   = 12,
    parameter int PTE_W       = 32,
    parameter int TLB_ENTRIES = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    output logic            rsp_valid,
    output logic [PA_W-1:0] rsp_paddr,
    output logic            rsp_fault,
    input  logic            base_we,
    input  logic [PA_W-1:0] base_wdata,
    output logic            mem_req_valid,
    output logic [PA_W-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data
);

    localparam int VPN_W = VA_W - PAGE_BITS;
    localparam int PFN_W = PA_W - PAGE_BITS;
    localparam int IDX_W = $clog2(TLB_ENTRIES);

    xl_state_e          state, state_nx;
    logic [VA_W-1:0]    va_q;
    logic [PTE_W-1:0]   pte_q;
    logic [PA_W-1:0]    base_q;

    logic [VPN_W-1:0]       va_vpn;
    logic [PFN_W-1:0]       pte_pfn;
    logic [PFN_W-1:0]       mem_pfn;
    logic                   lk_hit;
    logic [PFN_W-1:0]       lk_pfn;
    logic [TLB_ENTRIES-1:0] valid_vec;
    logic [IDX_W-1:0]       victim_idx;
    logic                   refill;

    assign va_vpn  = va_q[VA_W-1:PAGE_BITS];
    assign pte_pfn = pte_q[PTE_W-1 -: PFN_W];
    assign mem_pfn = mem_rsp_data[PTE_W-1 -: PFN_W];
    assign refill  = (state == ST_WALK_WAIT) && mem_rsp_valid
                     && mem_rsp_data[PTE_VALID_BIT];

    tlb_cam #(
        .ENTRIES (TLB_ENTRIES),
        .VPN_W   (VPN_W),
        .PFN_W   (PFN_W)
    ) i_cam (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (base_we),
        .wr_en     (refill),
        .wr_idx    (victim_idx),
        .wr_vpn    (va_vpn),
        .wr_pfn    (mem_pfn),
        .lk_vpn    (va_vpn),
        .lk_hit    (lk_hit),
        .lk_pfn    (lk_pfn),
        .valid_vec (valid_vec)
    );

    tlb_victim #(
        .ENTRIES (TLB_ENTRIES)
    ) i_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (base_we),
        .valid_vec  (valid_vec),
        .fill       (refill),
        .victim_idx (victim_idx)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q   <= '0;
            pte_q  <= '0;
            base_q <= '0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                va_q <= req_vaddr;
            end
            if (state == ST_WALK_WAIT && mem_rsp_valid) begin
                pte_q <= mem_rsp_data;
            end
            if (base_we) begin
                base_q <= base_wdata;
            end
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (req_valid)     state_nx = ST_LOOKUP;
            ST_LOOKUP:    state_nx = lk_hit ? ST_IDLE : ST_WALK_REQ;
            ST_WALK_REQ:  state_nx = ST_WALK_WAIT;
            ST_WALK_WAIT: if (mem_rsp_valid) state_nx = ST_DONE;
            ST_DONE:      state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready     = 1'b0;
        rsp_valid     = 1'b0;
        rsp_paddr     = '0;
        rsp_fault     = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_addr  = base_q + (PA_W'(va_vpn) << 2);
        unique case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_LOOKUP: begin
                if (lk_hit) begin
                    rsp_valid = 1'b1;
                    rsp_paddr = {lk_pfn, va_q[PAGE_BITS-1:0]};
                end
            end
            ST_WALK_REQ: mem_req_valid = 1'b1;
            ST_WALK_WAIT: ;
            ST_DONE: begin
                rsp_valid = 1'b1;
                if (pte_q[PTE_VALID_BIT]) begin
                    rsp_paddr = {pte_pfn, va_q[PAGE_BITS-1:0]};
                end else begin
                    rsp_fault = 1'b1;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mmu_xlate_chk.sv
module mmu_xlate_chk
    import mmu_pkg::*;
#(
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            rsp_fault,
    input logic            mem_req_valid,
    input logic            mem_rsp_valid,
    input xl_state_e       state
);

    // R7: the unit stops taking requests once one is taken
    p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R7: a response cycle is followed by readiness
    p_ready_after_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);

    // R7: no response while the unit is idle
    p_no_rsp_when_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !rsp_valid);

    // R10: the memory read is a single pulse
    p_single_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // R6: a fault carries a zero address
    p_fault_paddr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

    // R4: a walk answers in the cycle after the memory data
    p_rsp_after_mem_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WALK_WAIT && mem_rsp_valid) |=> rsp_valid);

    // R2: a hit does not start a walk
    p_hit_no_walk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOOKUP && rsp_valid) |=> !mem_req_valid);

endmodule

bind mmu_xlate mmu_xlate_chk #(.PA_W(PA_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault     (rsp_fault),
    .mem_req_valid (mem_req_valid),
    .mem_rsp_valid (mem_rsp_valid),
    .state         (state)
);

// File: tb/test_mmu_xlate.sv
module test_mmu_xlate;

    localparam int N         = 4;
    localparam int FAULT_VPN = 32'h00077;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic        base_we = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    always #2 clk = ~clk;

    mmu_xlate #(.TLB_ENTRIES(N)) i_mmu_xlate (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .rsp_valid     (rsp_valid),
        .rsp_paddr     (rsp_paddr),
        .rsp_fault     (rsp_fault),
        .base_we       (base_we),
        .base_wdata    (base_wdata),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Behavioural reference state
    bit          m_v   [N];
    int unsigned m_vpn [N];
    logic [19:0] m_pfn [N];
    int          m_rr  = 0;
    logic [31:0] m_base = '0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pte_at(input logic [31:0] addr);
        if (((addr - m_base) >> 2) == FAULT_VPN) return 32'h0;
        return {addr[21:2] ^ 20'h5A5A5, 11'h0, 1'b1};
    endfunction

    task automatic set_base(input logic [31:0] b);
        @(negedge clk);
        base_we    = 1'b1;
        base_wdata = b;
        @(negedge clk);
        base_we = 1'b0;
        for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        m_rr   = 0;
        m_base = b;
    endtask

    task automatic xlate(input logic [31:0] va, input int dly, input string tag);
        int unsigned vpn;
        int          hit_slot;
        logic [31:0] ea;
        logic [31:0] pte;
        int          slot;
        vpn = va[31:12];
        hit_slot = -1;
        for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == vpn) hit_slot = i;

        @(negedge clk);
        chk("R7 ready before request", {31'b0, req_ready}, 32'd1);
        req_valid = 1'b1;
        req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R7 busy after accept", {31'b0, req_ready}, 32'd0);
        chk({tag, " hit/miss path"}, {31'b0, rsp_valid}, (hit_slot >= 0) ? 32'd1 : 32'd0);

        if (hit_slot >= 0) begin
            chk("R2 hit fault flag", {31'b0, rsp_fault}, 32'd0);
            chk("R12 hit paddr", rsp_paddr, {m_pfn[hit_slot], va[11:0]});
            chk("R2 no read on hit", {31'b0, mem_req_valid}, 32'd0);
            @(negedge clk);
            chk("R10 no read after hit", {31'b0, mem_req_valid}, 32'd0);
        end else begin
            @(negedge clk);
            ea  = m_base + (vpn << 2);
            pte = pte_at(ea);
            chk("R3 read issued", {31'b0, mem_req_valid}, 32'd1);
            chk("R3 entry address", mem_req_addr, ea);
            for (int d = 0; d < dly; d++) begin
                @(negedge clk);
                chk("R10 single outstanding read", {31'b0, mem_req_valid}, 32'd0);
                chk("R4 no early response", {31'b0, rsp_valid}, 32'd0);
            end
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = pte;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_data  = '0;
            chk("R4 walk response", {31'b0, rsp_valid}, 32'd1);
            if (pte[0]) begin
                chk("R4 walk fault flag", {31'b0, rsp_fault}, 32'd0);
                chk("R12 walk paddr", rsp_paddr, {pte[31:12], va[11:0]});
                slot = -1;
                for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
                if (slot < 0) begin
                    slot = m_rr;
                    m_rr = (m_rr + 1) % N;
                end
                m_v[slot]   = 1'b1;
                m_vpn[slot] = vpn;
                m_pfn[slot] = pte[31:12];
            end else begin
                chk("R6 fault flag", {31'b0, rsp_fault}, 32'd1);
                chk("R6 fault paddr", rsp_paddr, 32'h0);
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset ready", {31'b0, req_ready}, 32'd1);
        chk("R1 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
        chk("R1 reset mem_req_valid", {31'b0, mem_req_valid}, 32'd0);

        set_base(32'h0010_0000);
        xlate(32'h0000_1234, 1, "R1");
        xlate(32'h0000_1ABC, 2, "R5");
        xlate(32'h0000_2000, 3, "R3");
        xlate(32'h8000_1004, 1, "R11");
        xlate(32'h0003_3FFF, 2, "R9");
        xlate(32'h0000_2010, 1, "R2");
        xlate(32'h8000_1FFF, 1, "R11");
        xlate(32'h0000_1000, 1, "R11");
        xlate(32'h0007_7000, 2, "R6");
        xlate(32'h0007_7123, 1, "R6");
        xlate(32'h0004_4000, 3, "R9");
        xlate(32'h0000_1000, 1, "R9");
        xlate(32'h0000_2000, 2, "R9");
        xlate(32'h0003_3000, 1, "R9");
        xlate(32'h8000_1000, 1, "R9");
        xlate(32'h0005_5000, 2, "R9");
        xlate(32'h0004_4ABC, 1, "R9");

        set_base(32'h0020_0000);
        xlate(32'h0003_3000, 2, "R8");
        xlate(32'h0003_3001, 1, "R8");
        xlate(32'h0000_1000, 3, "R8");
        xlate(32'h0007_7000, 1, "R6");
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule